// File: doc/BRIEF.md
# Retransmit FIFO with Depth Expansion

A single-clock first-in first-out buffer of 1024 words of 9 bits, stored in an internal register array. Writes and reads are requested with active-low strobes that are sampled on the clock edge. An active-low master reset clears the buffer. Three active-low status outputs report empty, full and more-than-half-full.

In single-device mode the shared control pin works as a retransmit request. It rewinds the read side to location zero so that stored data can be read again, while the write side stays where it is.

Several instances can be chained into one deeper buffer. Each expansion input is wired to the previous device's expansion output, and the last device's output returns to the first. A device may write only while it holds a write token and may read only while it holds a read token. When a device fills or drains its last location, it passes the matching token along with a one-cycle pulse. During reset the shared control pin marks the device that owns both tokens at start-up. The mode is chosen at reset. An expansion input held low gives single-device mode, and the shared output then carries the half-full flag. An expansion input that is high during reset gives chained mode, and the shared output then carries the token pulse.

Top module: `chain_fifo`

## Requirements
- R1: Accepted words are read back in write order. `dout` shows the word in the cycle after the clock edge that accepts the read, and holds it until the next accepted read.
- R2: A clock edge with `rst_n` low sets both pointers to location zero and `dout` to 0. It drives `empty_n` low, and `full_n` and `hf_xo_n` high.
- R3: A read request while `empty_n` is low is ignored: `dout` and the flags do not change.
- R4: A write request while `full_n` is low is ignored: the word is never stored and the buffer stays full.
- R5: The flags reflect the stored word count after each edge. `empty_n` is low exactly when the count is 0, and `full_n` is low exactly when the count is DEPTH (1024).
- R6: In single-device mode (`xi_n` low during reset), `hf_xo_n` is low exactly when the count exceeds DEPTH/2 (512).
- R7: In single-device mode, `fl_rt_n` low with `rst_n` high returns the read pointer to location zero and keeps the write pointer. The count becomes the write pointer value, meaning the total words written since reset when that total is below DEPTH. Reads and writes requested in that cycle are ignored, and the next reads restart from the first word written after reset.
- R8: In chained mode (`xi_n` high during reset), the device reset with `fl_rt_n` low owns both tokens and the other devices own none. Only a token holder accepts the matching strobe, and `fl_rt_n` has no effect outside reset.
- R9: In chained mode, `hf_xo_n` is low, in the same cycle, exactly while the device accepts a write to its last location or a read of its last location. It is high at all other times. The device then gives up that token.
- R10: In chained mode, the pulses a device receives on `xi_n` grant the write token and the read token in turn, the write token first after reset.
- R11: A write and a read requested in the same cycle are both carried out and the count is unchanged. On an empty buffer only the write takes effect, and on a full buffer only the read does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Master reset, active low, synchronous |
| wr_n | input | 1 | Write strobe, active low |
| din | input | DW | Write data |
| rd_n | input | 1 | Read strobe, active low |
| fl_rt_n | input | 1 | First-load marker during reset; retransmit request otherwise (single mode) |
| xi_n | input | 1 | Expansion input; low selects single-device mode |
| dout | output | DW | Read data |
| empty_n | output | 1 | Empty flag, active low |
| full_n | output | 1 | Full flag, active low |
| hf_xo_n | output | 1 | Half-full flag (single mode) or token pulse (chained mode), active low |

## Verification
A reference queue is kept alongside one full-size device. The bench fills it past the midpoint and back to it, which separates off-by-one errors in the half-full threshold. It runs a retransmit after partial reads while a write is also requested, which shows that the write pointer is kept and the stray write is dropped. It fills the device to full and pushes extra words, then drains it to empty and reads again, so each word pops in order exactly once. It issues paired read/write strobes on an empty and on a busy buffer. A two-device chain of depth 16 passes the write token forward and back and then the read token the same way. This tells apart correct token alternation, pulse timing at the last location and the data source after each handover.

// File: rtl/chain_fifo.sv
module chain_fifo #(
  parameter int DW = 9,
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1,
  localparam int HALF = DEPTH / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_n,
  input  logic [DW-1:0] din,
  input  logic          rd_n,
  input  logic          fl_rt_n,
  input  logic          xi_n,
  output logic [DW-1:0] dout,
  output logic          empty_n,
  output logic          full_n,
  output logic          hf_xo_n
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic exp_mode, wtok, rtok, rx_rd;

  wire retx   = rst_n & ~exp_mode & ~fl_rt_n;
  wire wr_ok  = rst_n & ~retx & ~wr_n & full_n & (~exp_mode | wtok);
  wire rd_ok  = rst_n & ~retx & ~rd_n & empty_n & (~exp_mode | rtok);
  wire w_last = wr_ok & (wp == AW'(DEPTH - 1));
  wire r_last = rd_ok & (rp == AW'(DEPTH - 1));
  wire xi_hit = rst_n & exp_mode & ~xi_n;
  wire over_half = cnt > CW'(HALF);

  assign empty_n = (cnt != '0);
  assign full_n  = (cnt != CW'(DEPTH));
  assign hf_xo_n = exp_mode ? ~(w_last | r_last) : ~over_half;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp       <= '0;
      rp       <= '0;
      cnt      <= '0;
      dout     <= '0;
      exp_mode <= xi_n;
      wtok     <= ~fl_rt_n;
      rtok     <= ~fl_rt_n;
      rx_rd    <= 1'b0;
    end else begin
      if (retx) begin
        rp  <= '0;
        cnt <= {1'b0, wp};
      end else begin
        if (wr_ok) wp <= wp + 1'b1;
        if (rd_ok) begin
          rp   <= rp + 1'b1;
          dout <= mem[rp];
        end
        case ({wr_ok, rd_ok})
          2'b10:   cnt <= cnt + 1'b1;
          2'b01:   cnt <= cnt - 1'b1;
          default: ;
        endcase
      end
      if (w_last) wtok <= 1'b0;
      else if (xi_hit && !rx_rd) wtok <= 1'b1;
      if (r_last) rtok <= 1'b0;
      else if (xi_hit && rx_rd) rtok <= 1'b1;
      if (xi_hit) rx_rd <= ~rx_rd;
    end
  end
endmodule

module chain_fifo_chk #(parameter int DW = 9) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_n,
  input logic          rd_n,
  input logic          fl_rt_n,
  input logic [DW-1:0] dout,
  input logic          empty_n,
  input logic          full_n,
  input logic          hf_xo_n,
  input logic          exp_mode
);
  assert_reset_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!empty_n && full_n && hf_xo_n && dout == '0));

  assert_empty_read_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n && wr_n && fl_rt_n) |=> (!empty_n && $stable(dout)));

  assert_full_write_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && rd_n && fl_rt_n) |=> !full_n);

  assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_n || full_n));

  assert_half_implies_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!exp_mode && !hf_xo_n) |-> empty_n);

  assert_pulse_needs_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_mode && !hf_xo_n) |-> (!wr_n || !rd_n));
endmodule

bind chain_fifo chain_fifo_chk #(.DW(DW)) u_chk (.*);

// File: tb/sim_chain_fifo.sv
`timescale 1ns/100ps
module sim_chain_fifo;
  localparam int DW = 9;
  localparam int D = 1024;
  localparam int CD = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, wr_n = 1'b1, rd_n = 1'b1, fl_rt_n = 1'b1;
  logic [DW-1:0] din = '0, dout;
  logic ef, ff, hf;

  chain_fifo #(.DW(DW), .DEPTH(D)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .din(din), .rd_n(rd_n),
    .fl_rt_n(fl_rt_n), .xi_n(1'b0), .dout(dout), .empty_n(ef), .full_n(ff), .hf_xo_n(hf));

  logic c_wr_n = 1'b1, c_rd_n = 1'b1;
  logic [DW-1:0] c_din = '0, c0_dout, c1_dout;
  logic c0_ef, c0_ff, c0_xo, c1_ef, c1_ff, c1_xo;

  chain_fifo #(.DW(DW), .DEPTH(CD)) u1 (
    .clk(clk), .rst_n(rst_n), .wr_n(c_wr_n), .din(c_din), .rd_n(c_rd_n),
    .fl_rt_n(1'b0), .xi_n(c1_xo), .dout(c0_dout), .empty_n(c0_ef), .full_n(c0_ff), .hf_xo_n(c0_xo));

  chain_fifo #(.DW(DW), .DEPTH(CD)) u2 (
    .clk(clk), .rst_n(rst_n), .wr_n(c_wr_n), .din(c_din), .rd_n(c_rd_n),
    .fl_rt_n(1'b1), .xi_n(c0_xo), .dout(c1_dout), .empty_n(c1_ef), .full_n(c1_ff), .hf_xo_n(c1_xo));

  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  int q[$], hist[$];
  bit pend = 0;
  int pexp;
  string ptag;

  int occ[2];
  int wdev, wpos, rdev, rpos;
  bit cpend = 0;
  int cpexp, cpdev;
  string ctag;

  always @(negedge clk) begin
    if (pend) begin chk(ptag, dout, pexp); pend = 0; end
    if (cpend) begin chk(ctag, (cpdev != 0) ? c1_dout : c0_dout, cpexp); cpend = 0; end
  end

  task automatic s_write(input int d);
    @(negedge clk); wr_n = 1'b0; din = d[DW-1:0];
    @(posedge clk); #1;
    if (q.size() < D) begin q.push_back(d & 511); hist.push_back(d & 511); end
    @(negedge clk); wr_n = 1'b1;
  endtask

  task automatic s_read(input string tag);
    @(negedge clk); rd_n = 1'b0;
    @(posedge clk); #1;
    if (q.size() > 0) begin pexp = q.pop_front(); ptag = tag; pend = 1; end
    @(negedge clk); rd_n = 1'b1;
  endtask

  task automatic s_both(input int d);
    int sz;
    @(negedge clk); rd_n = 1'b0; wr_n = 1'b0; din = d[DW-1:0];
    @(posedge clk); #1;
    sz = q.size();
    if (sz > 0) begin pexp = q.pop_front(); ptag = "R11"; pend = 1; end
    if (sz < D) q.push_back(d & 511);
    @(negedge clk); rd_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic s_retx();
    @(negedge clk); fl_rt_n = 1'b0; wr_n = 1'b0; din = 9'h1AA;
    @(posedge clk); #1;
    q = hist;
    @(negedge clk); fl_rt_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic s_flags(input string tag);
    chk({tag, " empty"}, ef, q.size() != 0);
    chk({tag, " full"}, ff, q.size() != D);
    chk({tag, " half"}, hf, !(q.size() > D / 2));
  endtask

  task automatic c_write(input int d, input string tag);
    bit acc, wrap;
    @(negedge clk); c_wr_n = 1'b0; c_din = d[DW-1:0];
    #1;
    acc = occ[wdev] < CD;
    wrap = acc && (wpos == CD - 1);
    if (wrap) chk({tag, " R9 write pulse"}, (wdev != 0) ? c1_xo : c0_xo, 1'b0);
    @(posedge clk); #1;
    if (acc) begin
      q.push_back(d & 511); occ[wdev]++; wpos++;
      if (wpos == CD) begin wpos = 0; wdev ^= 1; end
    end
    @(negedge clk); c_wr_n = 1'b1;
  endtask

  task automatic c_read(input string tag);
    bit acc, wrap;
    @(negedge clk); c_rd_n = 1'b0;
    #1;
    acc = occ[rdev] > 0;
    wrap = acc && (rpos == CD - 1);
    if (wrap) chk({tag, " R9 read pulse"}, (rdev != 0) ? c1_xo : c0_xo, 1'b0);
    @(posedge clk); #1;
    if (acc) begin
      cpexp = q.pop_front(); cpdev = rdev; ctag = tag; cpend = 1;
      occ[rdev]--; rpos++;
      if (rpos == CD) begin rpos = 0; rdev ^= 1; end
    end
    @(negedge clk); c_rd_n = 1'b1;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    s_flags("R2");
    chk("R2 dout", dout, 0);
    chk("R2 chain xo", c0_xo & c1_xo, 1);

    s_read("R3");
    chk("R3 dout after empty read", dout, 0);
    chk("R3 empty", ef, 0);

    for (int i = 0; i < 512; i++) s_write(i * 37 + 5);
    s_flags("R6 at 512");
    s_write(77);
    s_flags("R6 at 513");
    for (int i = 0; i < 87; i++) s_write(i * 11 + 3);
    for (int i = 0; i < 88; i++) s_read("R1");
    s_flags("R6 back to 512");

    s_retx();
    s_flags("R7 after retransmit");
    for (int i = 0; i < 5; i++) s_read("R7");

    while (q.size() < D) s_write(q.size() * 5 + 1);
    s_flags("R5 full");
    s_write(9'h155);
    s_write(9'h0AA);
    s_flags("R4 writes on full");
    while (q.size() > 0) s_read("R4 drain");
    s_flags("R5 empty");
    s_read("R3");
    s_flags("R3 after empty read");

    s_both(301);
    s_flags("R11 both on empty");
    s_write(302);
    s_both(303);
    s_both(304);
    s_flags("R11 both busy");
    while (q.size() > 0) s_read("R11");
    s_flags("R11 drained");

    q.delete();
    occ[0] = 0; occ[1] = 0; wdev = 0; wpos = 0; rdev = 0; rpos = 0;
    chk("R8 c0 empty", c0_ef, 0);
    chk("R8 c1 empty", c1_ef, 0);
    for (int i = 0; i < 20; i++) c_write(100 + i, "R8");
    chk("R8 c0 full", c0_ff, 0);
    chk("R8 c1 holds words", c1_ef, 1);
    for (int i = 0; i < 20; i++) c_read("R10 fwd");
    chk("R10 c0 empty", c0_ef, 0);
    for (int i = 0; i < 15; i++) c_write(200 + i, "R10");
    chk("R10 c0 got write token back", c0_ef, 1);
    for (int i = 0; i < 15; i++) c_read("R10 back");
    chk("R10 c0 drained", c0_ef, 0);
    chk("R10 c1 drained", c1_ef, 0);

    @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule